// File: doc/BRIEF.md
# Routing-Header TLV Selection Engine

This block sits beside the parser of an IPv6 segment routing header and decides which optional TLVs the local node has to act on. The TLV area is presented one byte per accepted beat, framed by a start marker on the first byte and an end marker on the last. With the area, the block receives the header's Segments Left value and a flag saying whether the active segment asks for TLV processing. It also takes a local-policy override and the type code that marks the processing-indicator TLV.

Only the first TLV can be the indicator. Its first four bytes are Type, Length (count of bytes after the Length byte), Bitmap Length (bytes per entry bitmap) and an index of the active entry. Entries follow at byte offset 4, entry 0 first. Each entry is one Segments-Left key byte followed by Bitmap Length bitmap bytes. The engine fetches the entry the index points at and compares its key with the header's Segments Left. On a match it expands the bitmap into a per-TLV enable mask. It also produces the index byte for the egress header, lowered by one on a match while it is above zero. Walking stops at the end marker, and the outcome is registered once and held until the next start.

Top module: `srh_tpi_select`

## Requirements
- R1: When neither the processing flavor flag nor the policy override is set at the end marker, the mask is all zero, both error flags are low and the index output equals the incoming index byte (byte 3 of the area).
- R2: The policy override enables indicator processing exactly as the flavor flag does.
- R3: When the first byte of the area differs from the indicator type input, the mask is all zero and the index output is zero.
- R4: A TLV whose type equals the indicator type but which is not the first TLV is never decoded as an indicator.
- R5: The selected entry starts at byte offset 4 + index x (1 + Bitmap Length). Its first byte is compared with Segments Left, using the index at byte 3 and Bitmap Length at byte 2.
- R6: On a key match with index above zero the index output is the index minus one; with index zero it stays zero.
- R7: On a key mismatch the mask is all zero and the index output equals the incoming index.
- R8: Mask bit n is bit (n mod 8) of bitmap byte n/8, counting bit 0 as the least significant bit and bitmap byte 0 as the first after the key; bit 0 enables the first TLV after the indicator.
- R9: If the selected entry ends beyond 1 + Length, or beyond the last byte received, malformed is raised and the mask is all zero.
- R10: If Bitmap Length exceeds the MAX_BL parameter, unsupported is raised, malformed stays low and the mask is all zero.
- R11: Results appear in the cycle after the beat carrying the end marker, stay unchanged until the next start marker, and mask_valid is low from the start beat until the next end marker.
- R12: After reset mask_valid is low and the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A TLV-area byte is present this cycle |
| in_sop | input | 1 | This byte is the first of the TLV area |
| in_last | input | 1 | This byte is the last of the TLV area |
| in_byte | input | 8 | TLV-area byte |
| seg_left | input | 8 | Segments Left of the header, held during the area |
| tpi_flavor | input | 1 | Active segment requests TLV processing |
| policy_override | input | 1 | Local policy forces indicator processing |
| ind_type | input | 8 | Type code of the indicator TLV |
| mask_valid | output | 1 | Outputs below hold a result |
| tlv_mask | output | 8*MAX_BL | Per-TLV enable, bit 0 for the TLV after the indicator |
| tpi_left_out | output | 8 | Index byte for the egress header |
| malformed | output | 1 | Selected entry does not fit the TLV or the stream |
| unsupported | output | 1 | Bitmap Length above MAX_BL |

## Verification
The main function is driven with a two-entry indicator at both indices, at a matching and a mismatching key, and with the flavor flag, the override or neither. Together these tell the index arithmetic apart from the key compare and the enable gating. Bitmaps of one, two and four bytes, with bits set at both ends of each byte, separate correct bit and byte ordering from a reversed one. Areas whose first TLV is not the indicator, or which carry the indicator type second, show that only the leading TLV is decoded. An out-of-range index, a truncated stream and an oversized bitmap length each show which error flag fires, and a gapped stream and a one-byte area exercise the framing.

// File: rtl/srh_tpi_pkg.sv
package srh_tpi_pkg;

    localparam int OFF_W = 16;
    localparam int EB_W  = 18;

    typedef struct packed {
        logic [7:0]       ty;
        logic [7:0]       len;
        logic [7:0]       bl;
        logic [7:0]       tl;
        logic [7:0]       sl;
        logic [OFF_W-1:0] nbytes;
    } tpi_hdr_t;

    // byte offset of the key byte of entry 'tl' inside the TLV area
    function automatic logic [EB_W-1:0] entry_base(input logic [7:0] tl, input logic [7:0] bl);
        return ({10'd0, tl} * ({10'd0, bl} + 18'd1)) + 18'd4;
    endfunction

endpackage

// File: rtl/tpi_byte_walker.sv
module tpi_byte_walker
    import srh_tpi_pkg::*;
#(
    parameter int MAX_BL = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_last,
    input  logic [7:0]            in_byte,
    output tpi_hdr_t              hdr_o,
    output logic [8*MAX_BL-1:0]   bm_o,
    output logic                  done_o
);
    localparam int BMW = 8 * MAX_BL;

    typedef struct packed {
        logic             active;
        tpi_hdr_t         hdr;
        logic [BMW-1:0]   bm;
    } walk_t;

    walk_t walk_d, walk_q;
    walk_t base;
    logic [EB_W-1:0] off_x, ebase, lim;

    always_comb begin
        base = walk_q;
        if (in_valid && in_sop) begin
            base.active = 1'b1;
            base.hdr    = '0;
            base.bm     = '0;
        end
        walk_d = walk_q;
        done_o = 1'b0;
        off_x  = {2'b00, base.hdr.nbytes};
        ebase  = entry_base(base.hdr.tl, base.hdr.bl);
        lim    = {10'd0, base.hdr.len} + 18'd1;
        if (in_valid && base.active) begin
            walk_d = base;
            case (base.hdr.nbytes)
                16'd0:   walk_d.hdr.ty  = in_byte;
                16'd1:   walk_d.hdr.len = in_byte;
                16'd2:   walk_d.hdr.bl  = in_byte;
                16'd3:   walk_d.hdr.tl  = in_byte;
                default: ;
            endcase
            if (off_x >= 18'd4 && off_x <= lim) begin
                if (off_x == ebase) walk_d.hdr.sl = in_byte;
                for (int b = 0; b < MAX_BL; b++) begin
                    if (b < int'(base.hdr.bl) && off_x == ebase + 18'(b) + 18'd1)
                        walk_d.bm[b*8 +: 8] = in_byte;
                end
            end
            if (base.hdr.nbytes != '1) walk_d.hdr.nbytes = base.hdr.nbytes + 1'b1;
            if (in_last) begin
                walk_d.active = 1'b0;
                done_o        = 1'b1;
            end
        end
        hdr_o = walk_d.hdr;
        bm_o  = walk_d.bm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

endmodule

// File: rtl/tpi_entry_judge.sv
module tpi_entry_judge
    import srh_tpi_pkg::*;
#(
    parameter int MAX_BL = 4
) (
    input  tpi_hdr_t              hdr,
    input  logic [8*MAX_BL-1:0]   bm,
    input  logic [7:0]            seg_left,
    input  logic                  tpi_flavor,
    input  logic                  policy_override,
    input  logic [7:0]            ind_type,
    output logic [8*MAX_BL-1:0]   mask,
    output logic [7:0]            tpi_out,
    output logic                  malformed,
    output logic                  unsupported
);
    logic            enabled, is_ind, hit;
    logic [EB_W-1:0] last_off;

    always_comb begin
        enabled     = tpi_flavor || policy_override;
        is_ind      = (hdr.nbytes != '0) && (hdr.ty == ind_type);
        last_off    = entry_base(hdr.tl, hdr.bl) + {10'd0, hdr.bl};
        unsupported = enabled && is_ind && (int'(hdr.bl) > MAX_BL);
        malformed   = enabled && is_ind && !unsupported &&
                      ((last_off > {10'd0, hdr.len} + 18'd1) ||
                       (last_off >= {2'b00, hdr.nbytes}));
        hit         = enabled && is_ind && !unsupported && !malformed &&
                      (hdr.sl == seg_left);
        mask        = hit ? bm : '0;
        if (!is_ind)                    tpi_out = 8'd0;
        else if (hit && hdr.tl != 8'd0) tpi_out = hdr.tl - 8'd1;
        else                            tpi_out = hdr.tl;
    end

endmodule

// File: rtl/srh_tpi_select.sv
module srh_tpi_select
    import srh_tpi_pkg::*;
#(
    parameter int MAX_BL = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_last,
    input  logic [7:0]            in_byte,
    input  logic [7:0]            seg_left,
    input  logic                  tpi_flavor,
    input  logic                  policy_override,
    input  logic [7:0]            ind_type,
    output logic                  mask_valid,
    output logic [8*MAX_BL-1:0]   tlv_mask,
    output logic [7:0]            tpi_left_out,
    output logic                  malformed,
    output logic                  unsupported
);
    localparam int MASK_W = 8 * MAX_BL;

    typedef struct packed {
        logic              valid;
        logic [MASK_W-1:0] mask;
        logic [7:0]        tpi;
        logic              mal;
        logic              uns;
    } res_t;

    tpi_hdr_t          hdr;
    logic [MASK_W-1:0] bm, j_mask;
    logic              done, j_mal, j_uns;
    logic [7:0]        j_tpi;
    res_t              res_d, res_q;

    tpi_byte_walker #(.MAX_BL(MAX_BL)) i_walker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_last(in_last), .in_byte(in_byte), .hdr_o(hdr), .bm_o(bm), .done_o(done)
    );

    tpi_entry_judge #(.MAX_BL(MAX_BL)) i_judge (
        .hdr(hdr), .bm(bm), .seg_left(seg_left), .tpi_flavor(tpi_flavor),
        .policy_override(policy_override), .ind_type(ind_type),
        .mask(j_mask), .tpi_out(j_tpi), .malformed(j_mal), .unsupported(j_uns)
    );

    always_comb begin
        res_d = res_q;
        if (in_valid && in_sop) res_d = '0;
        if (done) begin
            res_d.valid = 1'b1;
            res_d.mask  = j_mask;
            res_d.tpi   = j_tpi;
            res_d.mal   = j_mal;
            res_d.uns   = j_uns;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign mask_valid   = res_q.valid;
    assign tlv_mask     = res_q.mask;
    assign tpi_left_out = res_q.tpi;
    assign malformed    = res_q.mal;
    assign unsupported  = res_q.uns;

endmodule

// File: rtl/srh_tpi_select_chk.sv
module srh_tpi_select_chk #(
    parameter int MAX_BL = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_sop,
    input logic                  in_last,
    input logic                  tpi_flavor,
    input logic                  policy_override,
    input logic                  mask_valid,
    input logic [8*MAX_BL-1:0]   tlv_mask,
    input logic [7:0]            tpi_left_out,
    input logic                  malformed,
    input logic                  unsupported
);
    assert_zero_without_flavor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_valid) && !$past(tpi_flavor || policy_override) |-> tlv_mask == '0);

    assert_malformed_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid && malformed |-> tlv_mask == '0);

    assert_unsupported_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid && unsupported |-> tlv_mask == '0 && !malformed);

    assert_hold_until_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid && !(in_valid && in_sop) |=> mask_valid && $stable(tlv_mask) && $stable(tpi_left_out));

    assert_clear_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sop && !in_last |=> !mask_valid);

    assert_result_after_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sop && in_last |=> mask_valid);

    assert_idle_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_valid |-> tlv_mask == '0 && !malformed && !unsupported);
endmodule

bind srh_tpi_select srh_tpi_select_chk #(.MAX_BL(MAX_BL)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_last(in_last),
    .tpi_flavor(tpi_flavor), .policy_override(policy_override), .mask_valid(mask_valid),
    .tlv_mask(tlv_mask), .tpi_left_out(tpi_left_out), .malformed(malformed),
    .unsupported(unsupported)
);

// File: tb/test_srh_tpi_select.sv
`timescale 1ns/1ps
module test_srh_tpi_select;
    localparam int MAX_BL = 4;
    localparam int MW     = 8 * MAX_BL;
    localparam logic [7:0] IND = 8'h7E;

    typedef struct packed {
        logic [127:0] data;
        logic [7:0]   n;
        logic [7:0]   seg;
        logic         fl;
        logic         ov;
        logic [31:0]  mask;
        logic [7:0]   tpi;
        logic         mal;
        logic         uns;
    } vec_t;

    // R5 R8 R6 R7 R1 R2 R3 R4 R9 R10 cases
    localparam vec_t VECS [12] = '{
        '{128'h7E060101000C03030500050005000500, 8'd16, 8'd3, 1'b1, 1'b0, 32'h00000003, 8'd0, 1'b0, 1'b0},
        '{128'h7E060100000C03030500050005000500, 8'd16, 8'd0, 1'b1, 1'b0, 32'h0000000C, 8'd0, 1'b0, 1'b0},
        '{128'h7E060101000C03030500050005000500, 8'd16, 8'd2, 1'b1, 1'b0, 32'h00000000, 8'd1, 1'b0, 1'b0},
        '{128'h7E060101000C03030500050005000500, 8'd16, 8'd3, 1'b0, 1'b0, 32'h00000000, 8'd1, 1'b0, 1'b0},
        '{128'h7E060101000C03030500050005000500, 8'd16, 8'd3, 1'b0, 1'b1, 32'h00000003, 8'd0, 1'b0, 1'b0},
        '{128'h0502AABB050000000000000000000000, 8'd6,  8'd3, 1'b1, 1'b0, 32'h00000000, 8'd0, 1'b0, 1'b0},
        '{128'h05007E060101000C0303050000000000, 8'd12, 8'd3, 1'b1, 1'b0, 32'h00000000, 8'd0, 1'b0, 1'b0},
        '{128'h7E050200048102050000000000000000, 8'd9,  8'd4, 1'b1, 1'b0, 32'h00000281, 8'd0, 1'b0, 1'b0},
        '{128'h7E060102000C03030000000000000000, 8'd8,  8'd3, 1'b1, 1'b0, 32'h00000000, 8'd2, 1'b1, 1'b0},
        '{128'h7E07050001FFFFFFFFFF000000000000, 8'd10, 8'd1, 1'b1, 1'b0, 32'h00000000, 8'd0, 1'b0, 1'b1},
        '{128'h7E060101000C03000000000000000000, 8'd7,  8'd3, 1'b1, 1'b0, 32'h00000000, 8'd1, 1'b1, 1'b0},
        '{128'h7E070400020100008000000000000000, 8'd9,  8'd2, 1'b1, 1'b0, 32'h80000001, 8'd0, 1'b0, 1'b0}
    };
    localparam string VREQ [12] = '{"R5", "R6", "R7", "R1", "R2", "R3", "R4", "R8", "R9", "R10", "R9", "R8"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_last = 1'b0;
    logic [7:0] in_byte = '0, seg_left = '0, ind_type = IND;
    logic tpi_flavor = 1'b0, policy_override = 1'b0;
    logic mask_valid, malformed, unsupported;
    logic [MW-1:0] tlv_mask;
    logic [7:0] tpi_left_out;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    srh_tpi_select #(.MAX_BL(MAX_BL)) i_srh_tpi_select (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_last(in_last),
        .in_byte(in_byte), .seg_left(seg_left), .tpi_flavor(tpi_flavor),
        .policy_override(policy_override), .ind_type(ind_type), .mask_valid(mask_valid),
        .tlv_mask(tlv_mask), .tpi_left_out(tpi_left_out), .malformed(malformed),
        .unsupported(unsupported)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input vec_t v, input bit gaps);
        seg_left = v.seg; tpi_flavor = v.fl; policy_override = v.ov;
        for (int i = 0; i < int'(v.n); i++) begin
            @(negedge clk);
            if (i > 0) chk("R11", "valid during stream", 64'(mask_valid), 64'd0);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_last  = (i == int'(v.n) - 1);
            in_byte  = v.data[127 - 8*i -: 8];
            if (gaps && i != int'(v.n) - 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0;
    endtask

    task automatic expect_res(input string req, input vec_t v);
        chk("R11", "mask_valid after end", 64'(mask_valid), 64'd1);
        chk(req, "tlv_mask", 64'(tlv_mask), 64'(v.mask));
        chk(req, "tpi_left_out", 64'(tpi_left_out), 64'(v.tpi));
        chk(req, "malformed", 64'(malformed), 64'(v.mal));
        chk(req, "unsupported", 64'(unsupported), 64'(v.uns));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t one;
        logic [MW-1:0] held;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "mask_valid in reset", 64'(mask_valid), 64'd0);
        chk("R12", "tlv_mask in reset", 64'(tlv_mask), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "mask_valid after reset", 64'(mask_valid), 64'd0);

        for (int k = 0; k < 12; k++) begin
            send(VECS[k], 1'b0);
            expect_res(VREQ[k], VECS[k]);
        end

        // R8 R11: same area with idle cycles between bytes
        send(VECS[0], 1'b1);
        expect_res("R8", VECS[0]);

        // R11: result held while idle and inputs move
        held = tlv_mask;
        seg_left = 8'h55; tpi_flavor = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11", "mask held", 64'(tlv_mask), 64'(held));
        chk("R11", "index held", 64'(tpi_left_out), 64'd0);
        chk("R11", "valid held", 64'(mask_valid), 64'd1);

        // R11: start marker clears the previous result
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_last = 1'b0; in_byte = IND;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        chk("R11", "valid cleared by start", 64'(mask_valid), 64'd0);
        chk("R11", "mask cleared by start", 64'(tlv_mask), 64'd0);

        // R3: one-byte area of an ordinary TLV type
        one = '{128'h05000000000000000000000000000000, 8'd1, 8'd0, 1'b1, 1'b0, 32'h0, 8'd0, 1'b0, 1'b0};
        send(one, 1'b0);
        expect_res("R3", one);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule